// File: doc/BRIEF.md
# Four-Bit Two-Register ALU Datapath

This block is the execution half of a very small load/store processor. It holds two 4-bit working registers, called A and B, and a sixteen-function arithmetic/logic unit that always reads both of them. The only way to write a register is through a single shared write bus. A select pin steers either an external immediate value or the current ALU result onto that bus. Each register has its own load strobe and captures the bus on a rising clock edge while its strobe is high.

An external sequencer drives every control pin directly on every cycle: the immediate, the bus select, the two strobes, the carry-in and the opcode. A three-cycle program such as "load 5 into A, load 3 into B, compute A+B into A" is therefore a sequence of control words, one per clock. Both register contents are visible at the outputs at all times. A negative indication gives the sequencer the sign bit of whatever the ALU is computing in the current cycle, so it can branch on it.

The block has no streaming data path: every pin is a plain level sampled at the clock edge, so no valid/ready handshake or back-pressure applies. All arithmetic wraps modulo 2^W and any carry out of the top bit is dropped.

Top module: `alu4_datapath`

## Requirements
- R1: While `rst` is high at a rising edge, both registers become 0 on that edge, whatever the load strobes and bus select are.
- R2: With `bus_sel`=0, a register whose strobe is high takes `imm_x` on the rising edge.
- R3: With `bus_sel`=1, a register whose strobe is high takes the ALU result computed from the register values before that edge.
- R4: A register whose strobe is low keeps its value across the edge, whatever the other inputs are.
- R5: When both strobes are high in the same cycle, both registers take the identical bus value.
- R6: Opcode 0 gives ~A and opcode 1 gives ~B.
- R7: Opcodes 2, 3, 4, 5, 6 and 7 give A&B, A|B, ~(A&B), ~(A|B), A^B and ~(A^B), in that order.
- R8: Opcode 8 passes A unchanged and opcode 9 passes B unchanged.
- R9: Opcodes 10 and 11 give A+1 and B+1. Opcodes 12 and 13 give A-1 and B-1. All four wrap modulo 16 (15+1=0, 0-1=15).
- R10: Opcode 14 gives A+B and opcode 15 gives A+B+cin, modulo 16 with the carry-out discarded. `cin` has no effect on any opcode other than 15.
- R11: `neg` equals bit 3 of the current ALU result, combinationally, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of both registers |
| imm_x | input | 4 | Immediate value offered to the write bus |
| bus_sel | input | 1 | Write bus source: 0 = immediate, 1 = ALU result |
| ld_a | input | 1 | Load strobe of register A |
| ld_b | input | 1 | Load strobe of register B |
| cin | input | 1 | Carry-in, used only by opcode 15 |
| opcode | input | 4 | ALU function select |
| reg_a | output | 4 | Current contents of register A |
| reg_b | output | 4 | Current contents of register B |
| neg | output | 1 | Sign bit of the current ALU result |

## Verification
The bench targets the edges of the modular arithmetic: incrementing 15, decrementing 0, and adding 15+15+1. A design that kept a carry bit, or that sign-extended, would store 0 instead of 15 or leave a stale upper value. It drives `cin`=1 on every opcode other than 15; an adder that always used the carry-in would then be off by one on A+B or on the increments. It writes with both strobes high and with each strobe alone, which exposes a swapped strobe or a register fed from the wrong bus source. It samples `neg` in the same cycle as the opcode change, so a registered or mis-indexed sign bit shows up as the wrong polarity.

// File: rtl/alu4_pkg.sv
package alu4_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NOT_A  = 4'h0,
    OP_NOT_B  = 4'h1,
    OP_AND    = 4'h2,
    OP_OR     = 4'h3,
    OP_NAND   = 4'h4,
    OP_NOR    = 4'h5,
    OP_XOR    = 4'h6,
    OP_XNOR   = 4'h7,
    OP_PASS_A = 4'h8,
    OP_PASS_B = 4'h9,
    OP_INC_A  = 4'hA,
    OP_INC_B  = 4'hB,
    OP_DEC_A  = 4'hC,
    OP_DEC_B  = 4'hD,
    OP_ADD    = 4'hE,
    OP_ADDC   = 4'hF
  } alu_op_e;

  typedef enum logic {
    SRC_IMM = 1'b0,
    SRC_ALU = 1'b1
  } bus_src_e;

endpackage

// File: rtl/alu4_logic_unit.sv
module alu4_logic_unit
  import alu4_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y
);

  // Operands and results of the bitwise group (opcodes 0 to 7).
  logic [W-1:0] conj;
  logic [W-1:0] disj;
  logic [W-1:0] diff;

  assign conj = a & b;
  assign disj = a | b;
  assign diff = a ^ b;

  always_comb begin
    unique case (op)
      OP_NOT_A: y = ~a;
      OP_NOT_B: y = ~b;
      OP_AND:   y = conj;
      OP_OR:    y = disj;
      OP_NAND:  y = ~conj;
      OP_NOR:   y = ~disj;
      OP_XOR:   y = diff;
      OP_XNOR:  y = ~diff;
      default:  y = '0;
    endcase
  end

endmodule

// File: rtl/alu4_arith_unit.sv
module alu4_arith_unit
  import alu4_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  alu_op_e      op,
  output logic [W-1:0] y
);

  // One W-bit adder serves opcodes 8 to 15.
  // Opcode bit 0 picks A or B as the single operand for the pass, increment
  // and decrement opcodes.
  logic [W-1:0] single;
  logic [W-1:0] lhs;
  logic [W-1:0] rhs;
  logic         cy;

  assign single = op[0] ? b : a;

  always_comb begin
    lhs = single;
    rhs = '0;
    cy  = 1'b0;
    unique case (op)
      OP_PASS_A, OP_PASS_B: begin
        rhs = '0;
      end
      OP_INC_A, OP_INC_B: begin
        cy = 1'b1;
      end
      OP_DEC_A, OP_DEC_B: begin
        rhs = '1;
      end
      OP_ADD: begin
        lhs = a;
        rhs = b;
      end
      OP_ADDC: begin
        lhs = a;
        rhs = b;
        cy  = cin;
      end
      default: begin
        rhs = '0;
      end
    endcase
  end

  // The sum is truncated to W bits, so the carry-out is dropped.
  assign y = lhs + rhs + {{(W-1){1'b0}}, cy};

endmodule

// File: rtl/alu4_regs.sv
module alu4_regs #(
  parameter int W     = 4,
  parameter int NREGS = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [W-1:0]          wr_bus,
  input  logic [NREGS-1:0]      ld,
  output logic [NREGS-1:0][W-1:0] q
);

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        q[i] <= '0;
      end else if (ld[i]) begin
        q[i] <= wr_bus;
      end
    end
  end

endmodule

// File: rtl/alu4_datapath.sv
module alu4_datapath
  import alu4_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] imm_x,
  input  logic         bus_sel,
  input  logic         ld_a,
  input  logic         ld_b,
  input  logic         cin,
  input  logic [3:0]   opcode,
  output logic [W-1:0] reg_a,
  output logic [W-1:0] reg_b,
  output logic         neg
);

  localparam int NREGS = 2;
  localparam int IDX_A = 0;
  localparam int IDX_B = 1;

  alu_op_e                  op;
  bus_src_e                 src;
  logic [W-1:0]             y_logic;
  logic [W-1:0]             y_arith;
  logic [W-1:0]             alu_y;
  logic [W-1:0]             wr_bus;
  logic [NREGS-1:0]         ld_vec;
  logic [NREGS-1:0][W-1:0]  rq;

  assign op  = alu_op_e'(opcode);
  assign src = bus_src_e'(bus_sel);

  alu4_logic_unit #(.W(W)) u_logic (
    .a  (rq[IDX_A]),
    .b  (rq[IDX_B]),
    .op (op),
    .y  (y_logic)
  );

  alu4_arith_unit #(.W(W)) u_arith (
    .a   (rq[IDX_A]),
    .b   (rq[IDX_B]),
    .cin (cin),
    .op  (op),
    .y   (y_arith)
  );

  // Opcode bit 3 splits the map: bitwise functions below 8, adder above.
  assign alu_y  = opcode[3] ? y_arith : y_logic;
  assign wr_bus = (src == SRC_ALU) ? alu_y : imm_x;
  assign ld_vec = {ld_b, ld_a};

  alu4_regs #(.W(W), .NREGS(NREGS)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_bus (wr_bus),
    .ld     (ld_vec),
    .q      (rq)
  );

  assign reg_a = rq[IDX_A];
  assign reg_b = rq[IDX_B];
  assign neg   = alu_y[W-1];

endmodule

// File: rtl/alu4_datapath_chk.sv
module alu4_datapath_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] imm_x,
  input logic         bus_sel,
  input logic         ld_a,
  input logic         ld_b,
  input logic [3:0]   opcode,
  input logic [W-1:0] reg_a,
  input logic [W-1:0] reg_b,
  input logic         neg
);

  // Remembers whether reset was high at the previous edge, so the reset
  // check looks back only at an edge that really happened.
  logic rst_seen;
  logic rst_prev;

  initial begin
    rst_seen = 1'b0;
    rst_prev = 1'b0;
  end

  always @(posedge clk) begin
    rst_seen <= 1'b1;
    rst_prev <= rst;
  end

  always @(negedge clk) begin
    if (rst_seen && rst_prev) begin
      assert_reset_zero_R1: assert (reg_a == '0 && reg_b == '0)
        else $error("reset did not clear registers");
    end
  end

  property p_imm_load_a;
    @(posedge clk) disable iff (rst)
      (ld_a && !bus_sel) |=> (reg_a == $past(imm_x));
  endproperty
  assert_imm_load_R2: assert property (p_imm_load_a);

  property p_pass_into_b;
    @(posedge clk) disable iff (rst)
      (ld_b && bus_sel && opcode == 4'h8) |=> (reg_b == $past(reg_a));
  endproperty
  assert_alu_load_R3: assert property (p_pass_into_b);

  property p_hold_a;
    @(posedge clk) disable iff (rst)
      !ld_a |=> $stable(reg_a);
  endproperty
  assert_hold_a_R4: assert property (p_hold_a);

  property p_hold_b;
    @(posedge clk) disable iff (rst)
      !ld_b |=> $stable(reg_b);
  endproperty
  assert_hold_b_R4: assert property (p_hold_b);

  property p_dual_load;
    @(posedge clk) disable iff (rst)
      (ld_a && ld_b) |=> (reg_a == reg_b);
  endproperty
  assert_dual_load_R5: assert property (p_dual_load);

  property p_neg_msb;
    @(posedge clk) disable iff (rst)
      (ld_a && bus_sel) |=> (reg_a[W-1] == $past(neg));
  endproperty
  assert_neg_sign_R11: assert property (p_neg_msb);

endmodule

bind alu4_datapath alu4_datapath_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .imm_x   (imm_x),
  .bus_sel (bus_sel),
  .ld_a    (ld_a),
  .ld_b    (ld_b),
  .opcode  (opcode),
  .reg_a   (reg_a),
  .reg_b   (reg_b),
  .neg     (neg)
);

// File: tb/tb_alu4_datapath.sv
module tb_alu4_datapath;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 5000;

  logic       clk;
  logic       rst;
  logic [3:0] imm_x;
  logic       bus_sel;
  logic       ld_a;
  logic       ld_b;
  logic       cin;
  logic [3:0] opcode;
  logic [3:0] reg_a;
  logic [3:0] reg_b;
  logic       neg;

  alu4_datapath dut (
    .clk     (clk),
    .rst     (rst),
    .imm_x   (imm_x),
    .bus_sel (bus_sel),
    .ld_a    (ld_a),
    .ld_b    (ld_b),
    .cin     (cin),
    .opcode  (opcode),
    .reg_a   (reg_a),
    .reg_b   (reg_b),
    .neg     (neg)
  );

  typedef struct {
    logic [3:0] a;
    logic [3:0] b;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_errors = 0;
  bit   finished = 0;
  logic [3:0] mdl_a = '0;
  logic [3:0] mdl_b = '0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Expected ALU result, written straight from the opcode list.
  function automatic logic [3:0] ref_alu(logic [3:0] a, logic [3:0] b,
                                         logic c, logic [3:0] op);
    int s;
    case (op)
      4'd0:  s = 15 - a;
      4'd1:  s = 15 - b;
      4'd2:  s = a & b;
      4'd3:  s = a | b;
      4'd4:  s = 15 - (a & b);
      4'd5:  s = 15 - (a | b);
      4'd6:  s = a ^ b;
      4'd7:  s = 15 - (a ^ b);
      4'd8:  s = a;
      4'd9:  s = b;
      4'd10: s = a + 1;
      4'd11: s = b + 1;
      4'd12: s = a + 15;
      4'd13: s = b + 15;
      4'd14: s = a + b;
      default: s = a + b + c;
    endcase
    return 4'(s % 16);
  endfunction

  task automatic check1(string tag, int act, int expv);
    n_checks++;
    if (act != expv) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // Driver: applies one control word, checks neg for it, pushes the expected
  // register contents after the next edge.
  task automatic step(logic r, logic [3:0] x, logic s, logic la, logic lb,
                      logic c, logic [3:0] op, string tag);
    logic [3:0] y;
    logic [3:0] bus;
    exp_t e;
    @(negedge clk);
    rst = r; imm_x = x; bus_sel = s; ld_a = la; ld_b = lb; cin = c; opcode = op;
    #1;
    y = ref_alu(mdl_a, mdl_b, c, op);
    if (!r) check1({tag, " neg (R11)"}, neg, y[3]);
    bus = s ? y : x;
    if (r) begin
      mdl_a = '0; mdl_b = '0;
    end else begin
      if (la) mdl_a = bus;
      if (lb) mdl_b = bus;
    end
    e.a = mdl_a; e.b = mdl_b; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: after each edge compares the registers with the oldest item.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check1({e.tag, " reg_a"}, reg_a, e.a);
        check1({e.tag, " reg_b"}, reg_b, e.b);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * WDOG_CYCLES);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst = 1'b1; imm_x = '0; bus_sel = 1'b0; ld_a = 1'b0; ld_b = 1'b0;
    cin = 1'b0; opcode = '0;
    // R1: reset with strobes high and an immediate present.
    step(1, 4'd9, 0, 1, 1, 0, 4'd0, "R1 reset");
    step(1, 4'd7, 1, 1, 1, 1, 4'd14, "R1 reset alu src");
    // R2: immediate into A only, then into B only.
    step(0, 4'd5, 0, 1, 0, 0, 4'd0, "R2 imm to A");
    step(0, 4'd3, 0, 0, 1, 0, 4'd0, "R2 imm to B");
    // R4: no strobe, other inputs busy.
    step(0, 4'd12, 0, 0, 0, 1, 4'd15, "R4 hold imm");
    step(0, 4'd12, 1, 0, 0, 1, 4'd14, "R4 hold alu");
    // R6..R10: every opcode into A, A restored each time; cin=1 except op 15
    // is also tried with cin=0.
    for (int op = 0; op < 16; op++) begin
      step(0, 4'd6, 0, 1, 0, 0, 4'd0, "restore A");
      step(0, 4'd0, 1, 1, 0, (op != 15) ? 1'b1 : 1'b0, 4'(op),
           op < 2 ? "R6 complement" : op < 8 ? "R7 bitwise" :
           op < 10 ? "R8 pass" : op < 14 ? "R9 inc/dec" : "R10 add cin ignored/used");
    end
    // R3: ALU result into B (pass A, then A+B).
    step(0, 4'd11, 0, 1, 0, 0, 4'd0, "R2 imm to A");
    step(0, 4'd0, 1, 0, 1, 0, 4'd8, "R3 pass A into B");
    step(0, 4'd0, 1, 0, 1, 1, 4'd14, "R3 sum into B cin ignored R10");
    // R9 wrap: 15+1 and 0-1.
    step(0, 4'd15, 0, 1, 0, 0, 4'd0, "R2 imm 15");
    step(0, 4'd0, 1, 1, 0, 1, 4'd10, "R9 wrap inc");
    step(0, 4'd0, 1, 1, 0, 0, 4'd12, "R9 wrap dec");
    step(0, 4'd0, 1, 0, 1, 0, 4'd13, "R9 dec B");
    // R10 carry discarded: 15+15+1.
    step(0, 4'd15, 0, 1, 1, 0, 4'd0, "R5 both imm 15");
    step(0, 4'd0, 1, 1, 0, 1, 4'd15, "R10 15+15+1");
    step(0, 4'd0, 1, 1, 0, 1, 4'd14, "R10 15+15 cin ignored");
    // R5: both strobes with ALU source.
    step(0, 4'd2, 0, 0, 1, 0, 4'd0, "R2 imm to B");
    step(0, 4'd0, 1, 1, 1, 0, 4'd6, "R5 both from alu");
    step(0, 4'd9, 0, 1, 0, 0, 4'd0, "R11 neg from imm 9");
    step(0, 4'd0, 1, 0, 0, 0, 4'd8, "R11 pass negative");
    step(0, 4'd0, 1, 0, 0, 0, 4'd0, "R11 complement positive");
    // R1 again mid-run.
    step(1, 4'd4, 0, 1, 1, 0, 4'd0, "R1 reset midrun");
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end

endmodule